// File: doc/BRIEF.md
# Stacked Register Frame Manager

This block tracks the register window of a general register file that has 32 fixed registers and 96 stacked registers. It holds the current frame (a base pointer into the stacked pool, a frame size and a locals size) and one saved copy of the sizes of the frame that made the last call. Every frame begins at logical register 32. The locals occupy the low part of the frame and the outputs occupy the rest. A logical register number is translated each cycle into a physical stacked index. The same path reports whether the number names a fixed register or lies beyond the current frame.

Four commands act on the marker at a clock edge. A resize sets new frame and locals sizes in place. A call saves the current sizes and then advances the base past the caller's locals, so that the caller's outputs become the callee's inputs. A return restores the saved sizes and moves the base back by the restored locals count. A load-saved command writes the saved sizes from an operand, which lets software rebuild the chain for nested calls. Spilling registers to memory is not done. When the registers held across frames would exceed the pool, or the call nesting count would exceed its limit, the command is refused and a one-cycle overflow pulse is raised. A return with no outstanding call is refused with a one-cycle underflow pulse.

The controller is a two-state machine. FM_ROOT means no call is outstanding; FM_NESTED means at least one is. An accepted call moves FM_ROOT to FM_NESTED, and further accepted calls keep it in FM_NESTED. A return in FM_NESTED with a nesting count of one moves back to FM_ROOT, and with a larger count stays in FM_NESTED. A return in FM_ROOT stays in FM_ROOT and signals underflow. Resize and load-saved commands never change the state.

Top module: `frame_mgr`

## Requirements
- R1: After reset the base, frame size, locals size and both saved sizes are 0, the machine is in FM_ROOT, and neither flag is high.
- R2: A logical number below 32 gives preg_static=1, preg_illegal=0 and preg_idx=0.
- R3: A logical number n of 32 or more gives preg_idx=(base+n-32) mod 96 and preg_illegal=1 exactly when n-32 is at least the current frame size.
- R4: Translation is combinational and uses the marker from before the edge, even while a command is pending.
- R5: A call (cmd_op=1) copies the current sizes into the saved sizes, sets base to (base+locals) mod 96, sets frame size to frame-locals and locals to 0, and adds the old locals to the held-locals count.
- R6: A resize (cmd_op=0) sets frame and locals sizes from cmd_sof and cmd_sol, leaves base and saved sizes unchanged.
- R7: A resize whose cmd_sof plus the held-locals count exceeds 96 changes nothing and raises ovf_pulse for one cycle.
- R8: A return (cmd_op=2) in FM_NESTED loads the current sizes from the saved sizes, sets base to (base-restored locals) mod 96, lowers the held-locals count by the restored locals, and leaves the saved sizes unchanged.
- R9: A return in FM_ROOT changes nothing and raises unf_pulse for one cycle.
- R10: A load-saved command (cmd_op=3) sets the saved sizes from cmd_sof and cmd_sol and leaves the current frame unchanged.
- R11: A call while the nesting count is at its maximum (255 by default) changes nothing and raises ovf_pulse for one cycle.
- R12: With cmd_valid low nothing changes and no flag rises, whatever the other command inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is applied at this edge |
| cmd_op | input | 2 | 0 resize, 1 call, 2 return, 3 load-saved |
| cmd_sof | input | 7 | Frame size operand |
| cmd_sol | input | 7 | Locals size operand |
| lreg | input | 7 | Logical register number to translate |
| preg_idx | output | 7 | Physical stacked index, 0 to 95 |
| preg_static | output | 1 | lreg names a fixed register |
| preg_illegal | output | 1 | lreg lies beyond the current frame |
| cur_base | output | 7 | Current frame base in the stacked pool |
| cur_sof | output | 7 | Current frame size |
| cur_sol | output | 7 | Current locals size |
| prev_sof | output | 7 | Saved frame size |
| prev_sol | output | 7 | Saved locals size |
| ovf_pulse | output | 1 | One-cycle pulse for a refused resize or call |
| unf_pulse | output | 1 | One-cycle pulse for a refused return |

## Verification
The assertions assume that every resize and load-saved operand keeps the locals size no larger than the frame size, and that load-saved sizes stay at or below 96. Under that assumption the base stays below 96 and the translated index stays in range. The stimulus table and the directed tests use only operands of that kind. Overflow is reached only through the sum of the held locals and the new frame size, never through an out-of-range operand.

// File: rtl/fm_pkg.sv
package fm_pkg;
    localparam int NUM_REGS   = 128;
    localparam int NUM_STATIC = 32;
    localparam int NUM_STACK  = NUM_REGS - NUM_STATIC;
    localparam int REG_W      = $clog2(NUM_REGS);

    typedef logic [REG_W-1:0] reg_t;
    typedef logic [REG_W:0]   wide_t;

    localparam wide_t STACK_N  = wide_t'(NUM_STACK);
    localparam reg_t  STATIC_N = reg_t'(NUM_STATIC);

    typedef enum logic [1:0] {
        OP_ALLOC  = 2'd0,
        OP_CALL   = 2'd1,
        OP_RET    = 2'd2,
        OP_SETPFM = 2'd3
    } fm_op_e;

    typedef enum logic {
        FM_ROOT   = 1'b0,
        FM_NESTED = 1'b1
    } fm_state_e;

    typedef struct packed {
        reg_t sof;
        reg_t sol;
    } frame_sz_t;

    // (b + o) mod pool size, for b below the pool size and o at most the pool size
    function automatic reg_t wrap_add(reg_t b, reg_t o);
        wide_t s;
        s = {1'b0, b} + {1'b0, o};
        if (s >= STACK_N) s = s - STACK_N;
        return s[REG_W-1:0];
    endfunction

    // (b - o) mod pool size
    function automatic reg_t wrap_sub(reg_t b, reg_t o);
        wide_t s;
        s = {1'b0, b} + STACK_N - {1'b0, o};
        if (s >= STACK_N) s = s - STACK_N;
        return s[REG_W-1:0];
    endfunction
endpackage

// File: rtl/fm_xlate.sv
module fm_xlate
    import fm_pkg::*;
(
    input  reg_t lreg,
    input  reg_t base,
    input  reg_t sof,
    output reg_t idx,
    output logic is_static,
    output logic illegal
);
    reg_t off;

    always_comb begin
        is_static = (lreg < STATIC_N);
        off       = lreg - STATIC_N;
        illegal   = !is_static && (off >= sof);
        idx       = is_static ? '0 : wrap_add(base, off);
    end
endmodule

// File: rtl/fm_ctrl.sv
module fm_ctrl
    import fm_pkg::*;
#(
    parameter int DEPTH_W = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cmd_valid,
    input  fm_op_e    cmd_op,
    input  frame_sz_t cmd_sz,
    output reg_t      cur_base,
    output frame_sz_t cur_sz,
    output frame_sz_t pfm_sz,
    output logic      ovf_q,
    output logic      unf_q
);
    localparam logic [DEPTH_W-1:0] DEPTH_MAX = '1;
    localparam logic [DEPTH_W-1:0] DEPTH_ONE = DEPTH_W'(1);

    fm_state_e          state, state_n;
    reg_t               base_n;
    frame_sz_t          sz_n, pfm_n;
    wide_t              held, held_n, held_sum;
    logic [DEPTH_W-1:0] depth, depth_n;
    logic               ovf_n, unf_n;

    // state and marker registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= FM_ROOT;
            cur_base <= '0;
            cur_sz   <= '0;
            pfm_sz   <= '0;
            held     <= '0;
            depth    <= '0;
            ovf_q    <= 1'b0;
            unf_q    <= 1'b0;
        end else begin
            state    <= state_n;
            cur_base <= base_n;
            cur_sz   <= sz_n;
            pfm_sz   <= pfm_n;
            held     <= held_n;
            depth    <= depth_n;
            ovf_q    <= ovf_n;
            unf_q    <= unf_n;
        end
    end

    // next state and marker updates
    always_comb begin
        state_n  = state;
        base_n   = cur_base;
        sz_n     = cur_sz;
        pfm_n    = pfm_sz;
        held_n   = held;
        depth_n  = depth;
        ovf_n    = 1'b0;
        unf_n    = 1'b0;
        held_sum = held + {1'b0, cur_sz.sol};
        if (cmd_valid) begin
            unique case (cmd_op)
                OP_ALLOC: begin
                    if (({1'b0, cmd_sz.sof} + held) > STACK_N) ovf_n = 1'b1;
                    else sz_n = cmd_sz;
                end
                OP_CALL: begin
                    if (depth == DEPTH_MAX) ovf_n = 1'b1;
                    else begin
                        pfm_n    = cur_sz;
                        base_n   = wrap_add(cur_base, cur_sz.sol);
                        sz_n.sof = cur_sz.sof - cur_sz.sol;
                        sz_n.sol = '0;
                        held_n   = (held_sum > STACK_N) ? STACK_N : held_sum;
                        depth_n  = depth + DEPTH_ONE;
                        state_n  = FM_NESTED;
                    end
                end
                OP_RET: begin
                    unique case (state)
                        FM_ROOT: unf_n = 1'b1;
                        FM_NESTED: begin
                            sz_n    = pfm_sz;
                            base_n  = wrap_sub(cur_base, pfm_sz.sol);
                            held_n  = (held >= {1'b0, pfm_sz.sol}) ?
                                      held - {1'b0, pfm_sz.sol} : '0;
                            depth_n = depth - DEPTH_ONE;
                            state_n = (depth == DEPTH_ONE) ? FM_ROOT : FM_NESTED;
                        end
                    endcase
                end
                OP_SETPFM: pfm_n = cmd_sz;
            endcase
        end
    end

    // R7, R11: a refused command leaves the marker as it was
    a_r7_refused_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> $stable(cur_base) && $stable(cur_sz) && $stable(pfm_sz));

    // R9: underflow only follows a return and changes nothing
    a_r9_underflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
        unf_q |-> $past(cmd_valid && cmd_op == OP_RET) && $stable(cur_base) && $stable(cur_sz));

    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_q && unf_q));

    // R12: idle cycle changes nothing
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cmd_valid) |-> !ovf_q && !unf_q && $stable(cur_base) && $stable(cur_sz) && $stable(pfm_sz));

    // R5: accepted call leaves no locals and saves the caller sizes
    a_r5_call_saves: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_valid && cmd_op == OP_CALL) && !ovf_q |-> cur_sz.sol == '0 && pfm_sz == $past(cur_sz));

    // R8: accepted return restores the saved sizes
    a_r8_ret_restores: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_valid && cmd_op == OP_RET) && !unf_q |-> cur_sz == $past(pfm_sz) && $stable(pfm_sz));

    a_r3_base_in_pool: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, cur_base} < STACK_N);
endmodule

// File: rtl/frame_mgr.sv
module frame_mgr
    import fm_pkg::*;
#(
    parameter int DEPTH_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [REG_W-1:0] cmd_sof,
    input  logic [REG_W-1:0] cmd_sol,
    input  logic [REG_W-1:0] lreg,
    output logic [REG_W-1:0] preg_idx,
    output logic             preg_static,
    output logic             preg_illegal,
    output logic [REG_W-1:0] cur_base,
    output logic [REG_W-1:0] cur_sof,
    output logic [REG_W-1:0] cur_sol,
    output logic [REG_W-1:0] prev_sof,
    output logic [REG_W-1:0] prev_sol,
    output logic             ovf_pulse,
    output logic             unf_pulse
);
    frame_sz_t cur_sz, pfm_sz, cmd_sz;

    assign cmd_sz = '{sof: cmd_sof, sol: cmd_sol};

    fm_ctrl #(.DEPTH_W(DEPTH_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (fm_op_e'(cmd_op)),
        .cmd_sz    (cmd_sz),
        .cur_base  (cur_base),
        .cur_sz    (cur_sz),
        .pfm_sz    (pfm_sz),
        .ovf_q     (ovf_pulse),
        .unf_q     (unf_pulse)
    );

    fm_xlate u_xlate (
        .lreg      (lreg),
        .base      (cur_base),
        .sof       (cur_sz.sof),
        .idx       (preg_idx),
        .is_static (preg_static),
        .illegal   (preg_illegal)
    );

    assign cur_sof  = cur_sz.sof;
    assign cur_sol  = cur_sz.sol;
    assign prev_sof = pfm_sz.sof;
    assign prev_sol = pfm_sz.sol;

    // R3: translated index stays inside the pool
    a_r3_idx_in_pool: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, preg_idx} < STACK_N);

    // R2: a fixed register is never out of frame
    a_r2_static_legal: assert property (@(posedge clk) disable iff (!rst_n)
        preg_static |-> !preg_illegal && preg_idx == '0);
endmodule

// File: tb/tb_frame_mgr.sv
module tb_frame_mgr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [6:0] cmd_sof = '0, cmd_sol = '0, lreg = '0;
    logic [6:0] preg_idx, cur_base, cur_sof, cur_sol, prev_sof, prev_sol;
    logic       preg_static, preg_illegal, ovf_pulse, unf_pulse;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    frame_mgr dut (.*);

    typedef struct packed {
        logic [3:0] req;
        logic       v;
        logic [1:0] op;
        logic [6:0] sof, sol, lr;
        logic [6:0] eb, esof, esol, epsof, epsol, eidx;
        logic       eill, eovf, eunf;
    } vec_t;

    // op: 0 resize, 1 call, 2 return, 3 load-saved
    localparam vec_t VECS [22] = '{
        '{6,  1, 0, 21, 14, 46,  0, 21, 14,  0,  0, 14, 0, 0, 0}, // R6
        '{5,  1, 1,  0,  0, 32, 14,  7,  0, 21, 14, 14, 0, 0, 0}, // R5 callee r32 = caller r46
        '{12, 0, 0, 90, 90, 39, 14,  7,  0, 21, 14, 21, 1, 0, 0}, // R12, R3 illegal
        '{6,  1, 0, 19, 16, 50, 14, 19, 16, 21, 14, 32, 0, 0, 0}, // R6
        '{8,  1, 2,  0,  0, 46,  0, 21, 14, 21, 14, 14, 0, 0, 0}, // R8
        '{9,  1, 2,  0,  0, 52,  0, 21, 14, 21, 14, 20, 0, 0, 1}, // R9
        '{6,  1, 0, 96, 90,127,  0, 96, 90, 21, 14, 95, 0, 0, 0}, // R6 full pool
        '{5,  1, 1,  0,  0, 37, 90,  6,  0, 96, 90, 95, 0, 0, 0}, // R5
        '{7,  1, 0, 10,  4, 35, 90,  6,  0, 96, 90, 93, 0, 1, 0}, // R7 90+10>96
        '{6,  1, 0,  6,  2, 36, 90,  6,  2, 96, 90, 94, 0, 0, 0}, // R6
        '{5,  1, 1,  0,  0, 35, 92,  4,  0,  6,  2, 95, 0, 0, 0}, // R5
        '{6,  1, 0,  4,  4, 35, 92,  4,  4,  6,  2, 95, 0, 0, 0}, // R6 exactly 96
        '{5,  1, 1,  0,  0, 32,  0,  0,  0,  4,  4,  0, 1, 0, 0}, // R5 base wraps to 0
        '{7,  1, 0,  1,  0, 32,  0,  0,  0,  4,  4,  0, 1, 1, 0}, // R7 97>96
        '{10, 1, 3,  6,  2, 10,  0,  0,  0,  6,  2,  0, 0, 0, 0}, // R10, R2
        '{8,  1, 2,  0,  0, 36, 94,  6,  2,  6,  2,  2, 0, 0, 0}, // R8 base wraps down
        '{8,  1, 2,  0,  0, 33, 92,  6,  2,  6,  2, 93, 0, 0, 0}, // R8
        '{10, 1, 3, 96, 90, 33, 92,  6,  2, 96, 90, 93, 0, 0, 0}, // R10
        '{8,  1, 2,  0,  0, 32,  2, 96, 90, 96, 90,  2, 0, 0, 0}, // R8
        '{7,  1, 0, 95,  0, 32,  2, 96, 90, 96, 90,  2, 0, 1, 0}, // R7 held 2
        '{6,  1, 0, 94,  0,127,  2, 94,  0, 96, 90,  1, 1, 0, 0}, // R6, R3 wrap
        '{9,  1, 2,  0,  0,127,  2, 94,  0, 96, 90,  1, 1, 0, 1}  // R9
    };

    task automatic chk(input int req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] op, input logic [6:0] sof,
                         input logic [6:0] sol, input logic [6:0] lr);
        cmd_valid = v; cmd_op = op; cmd_sof = sof; cmd_sol = sol; lreg = lr;
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        drive(0, 0, 0, 0, 32);
        step();
        step();
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R1: reset state
        chk(1, "base", cur_base, 0);
        chk(1, "sof", cur_sof, 0);
        chk(1, "sol", cur_sol, 0);
        chk(1, "prev_sof", prev_sof, 0);
        chk(1, "prev_sol", prev_sol, 0);
        chk(1, "flags", {ovf_pulse, unf_pulse}, 0);
        chk(1, "r32 illegal in empty frame", preg_illegal, 1);

        foreach (VECS[i]) begin
            drive(VECS[i].v, VECS[i].op, VECS[i].sof, VECS[i].sol, VECS[i].lr);
            step();
            chk(VECS[i].req, $sformatf("v%0d base", i), cur_base, VECS[i].eb);
            chk(VECS[i].req, $sformatf("v%0d sof", i), cur_sof, VECS[i].esof);
            chk(VECS[i].req, $sformatf("v%0d sol", i), cur_sol, VECS[i].esol);
            chk(VECS[i].req, $sformatf("v%0d prev", i), {prev_sof, prev_sol}, {VECS[i].epsof, VECS[i].epsol});
            chk(VECS[i].req, $sformatf("v%0d idx", i), preg_idx, VECS[i].eidx);
            chk(VECS[i].req, $sformatf("v%0d illegal", i), preg_illegal, VECS[i].eill);
            chk(VECS[i].req, $sformatf("v%0d ovf", i), ovf_pulse, VECS[i].eovf);
            chk(VECS[i].req, $sformatf("v%0d unf", i), unf_pulse, VECS[i].eunf);
        end
        drive(0, 0, 0, 0, 32);
        step();
        chk(7, "overflow pulse lasts one cycle", ovf_pulse, 0);

        // R2: fixed registers
        lreg = 7'd0;
        #1 chk(2, "r0 static", {preg_static, preg_illegal, preg_idx}, {1'b1, 1'b0, 7'd0});
        lreg = 7'd31;
        #1 chk(2, "r31 static", {preg_static, preg_illegal, preg_idx}, {1'b1, 1'b0, 7'd0});
        lreg = 7'd32;
        #1 chk(3, "r32 not static", preg_static, 0);

        // R4: translation uses the pre-edge marker
        do_reset();
        drive(1, 0, 21, 14, 40);
        step();
        drive(1, 1, 0, 0, 40);
        #1;
        chk(4, "idx before call edge", preg_idx, 8);
        chk(4, "illegal before call edge", preg_illegal, 0);
        step();
        chk(4, "idx after call edge", preg_idx, 22);
        chk(4, "illegal after call edge", preg_illegal, 1);

        // R11: nesting limit
        do_reset();
        for (int k = 0; k < 255; k++) begin
            drive(1, 1, 0, 0, 32);
            step();
            if (ovf_pulse) chk(11, "call below limit refused", 1, 0);
        end
        drive(1, 3, 5, 3, 32);
        step();
        drive(1, 1, 0, 0, 32);
        step();
        chk(11, "call at limit overflow", ovf_pulse, 1);
        chk(11, "call at limit keeps saved", {prev_sof, prev_sol}, {7'd5, 7'd3});
        drive(1, 2, 0, 0, 32);
        step();
        chk(11, "return after limit", {unf_pulse, cur_sof, cur_sol}, {1'b0, 7'd5, 7'd3});
        chk(11, "return after limit base", cur_base, 93);

        drive(0, 0, 0, 0, 32);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule